// File: doc/BRIEF.md
# Checked Packet Retry Controller

This block sits where a duplicated, compared logic domain hands message packets to a single-rail I/O path. It takes a packet from the compared side, stores it, and sends it over the selected path with a 16-bit check word added at the end. It then waits for the packet that comes back and checks that packet's check word. Check words are only made and checked here; the single-rail path just carries them.

When a returning packet fails its check, the block recovers in hardware. It first resends the stored packet on the same path. If that fails, it resends on the next path. If that also fails, it raises an escalation request for software and holds until the request is acknowledged. A transfer that recovers after a retry leaves an entry in a small log FIFO. Every failed attempt is counted per path. When a count passes a threshold, a reconfiguration request for that path goes high.

Top module: `checked_retry_ctrl`

## Requirements
- R1: For each attempt, the block sends the stored payload words in arrival order and then one code word with `tx_last` high. The code is a CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed most significant bit first over every bit of each payload word, with no final inversion. It sits in the low 16 bits of the word and the upper bits are zero.
- R2: The first attempt uses the path given on `pri_path` together with the last upstream word, and that path appears on `tx_path`.
- R3: A returning packet passes when it has at least one word before its last word and its last word equals the CRC (as in R1) of those words. `xfer_ok` is then high for the one cycle after the final handshake, and `s_ready` returns high.
- R4: After the first failed return, the whole packet is sent again on the same path.
- R5: After the second failed return, the packet is sent again on path (p+1) mod N_PATH, where p is the first-attempt path.
- R6: After the third failed return, `esc_req` stays high, nothing is sent and `s_ready` stays low until `esc_ack`. The block then goes idle and drops the packet.
- R7: A pass after one or more retries pushes one log entry. In that entry, bit 0 is the class of the first fault (0 = code mismatch, 1 = return with no word before its last). Bits 2:1 hold the retry count (1 or 2), and the bits above them hold the path that passed. A pass on the first attempt pushes nothing.
- R8: Log entries come out in push order through `log_valid`/`log_entry`/`log_pop`. A push into a full log that is not popped in the same cycle is dropped and sets `log_ovf`, which stays set until reset.
- R9: Every failed return adds one to the counter of the path used. Counter p is `err_cnt[p*CNT_W +: CNT_W]`, and it holds at all ones.
- R10: `reconfig_req[p]` is high while counter p is above THRESH. `err_clr[p]` zeroes counter p and no other counter.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last` and `tx_path` hold their values.
- R12: After reset, `s_ready` is 1 and `tx_valid`, `rx_ready`, `esc_req`, `log_valid`, `log_ovf`, `xfer_ok` and every counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Upstream payload word valid |
| s_ready | output | 1 | Block can take an upstream word (idle) |
| s_data | input | DATA_W | Upstream payload word |
| s_last | input | 1 | Marks the last upstream word of a packet |
| pri_path | input | PATH_W | First-attempt path, sampled with the last word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_ready | input | 1 | Path accepts the outgoing word |
| tx_data | output | DATA_W | Outgoing payload or code word |
| tx_last | output | 1 | Outgoing code word marker |
| tx_path | output | PATH_W | Path used for the current attempt |
| rx_valid | input | 1 | Returning word valid |
| rx_ready | output | 1 | Block is waiting for the returning packet |
| rx_data | input | DATA_W | Returning word |
| rx_last | input | 1 | Returning code word marker |
| xfer_ok | output | 1 | One-cycle pulse when a transfer passes |
| esc_req | output | 1 | Hardware retries exhausted |
| esc_ack | input | 1 | Software has taken the escalation |
| log_valid | output | 1 | Log holds at least one entry |
| log_entry | output | PATH_W+3 | Oldest log entry |
| log_pop | input | 1 | Removes the oldest log entry |
| log_ovf | output | 1 | Sticky flag for a dropped log entry |
| err_clr | input | N_PATH | Per-path counter clear |
| err_cnt | output | N_PATH*CNT_W | Per-path failed-attempt counters |
| reconfig_req | output | N_PATH | Per-path threshold-exceeded request |

## Verification
The bench first targets the retry order. A design that retried on the alternate path first, or that escalated one attempt early or late, would show the wrong `tx_path` or an unexpected resent word in the scoreboard. A return with no word before its code word is used as a fault of its own class. A design that treated it as a pass, or logged the wrong class, would be caught through `xfer_ok` and the popped log entry. The log is filled and then pushed once more, which exposes a design that overwrites an entry or forgets the overflow flag. Counters are driven into saturation and then cleared on one path only. This exposes wrap-around, a shared clear, or an off-by-one in the threshold compare. A stretch with `tx_ready` toggling checks that outgoing words hold and are not skipped.

// File: rtl/prc_pkg.sv
package prc_pkg;

   localparam int CRC_W = 16;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
   localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;

   localparam logic FLT_MISMATCH = 1'b0;
   localparam logic FLT_EMPTY    = 1'b1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_CODE,
      ST_WAIT,
      ST_ESC
   } xfer_state_t;

   // Bitwise CRC step over the low `width` bits of a word, MSB first.
   function automatic logic [CRC_W-1:0] crc_update(input logic [CRC_W-1:0] crc_in,
                                                    input logic [63:0] word,
                                                    input int width);
      logic [CRC_W-1:0] c;
      logic fb;
      c = crc_in;
      for (int i = 63; i >= 0; i--) begin
         if (i < width) begin
            fb = c[CRC_W-1] ^ word[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/prc_pkt_buf.sv
module prc_pkt_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("prc_pkt_buf: DEPTH must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en && !clr) begin
         mem[count[IDX_W-1:0]] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (wr_en) begin
         count <= count + 1'b1;
      end
   end

   assign rd_data = mem[rd_idx];

   // R1: a packet never holds more words than the replay store.
   assert_buf_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (count < CNT_W'(DEPTH)));

endmodule

// File: rtl/prc_err_log.sv
module prc_err_log #(
   parameter int ENTRY_W = 4,
   parameter int DEPTH   = 2,
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic               out_valid,
   output logic [ENTRY_W-1:0] out_data,
   output logic               ovf
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("prc_err_log: DEPTH must be a power of two, at least 2");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [PTR_W:0]     fill;
   logic               full, do_pop, do_push;

   assign full      = (fill == (PTR_W+1)'(DEPTH));
   assign out_valid = (fill != '0);
   assign out_data  = mem[rd_ptr];
   assign do_pop    = pop && out_valid;
   assign do_push   = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
         if (push && !do_push) ovf <= 1'b1;
      end
   end

   // R8: a push into a full, unpopped log is dropped and flagged.
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop |=> ovf && full);

   // R8: the overflow flag is sticky.
   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

endmodule

// File: rtl/prc_fault_cnt.sv
module prc_fault_cnt #(
   parameter int N_SRC  = 2,
   parameter int CNT_W  = 3,
   parameter int THRESH = 3,
   localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inc_en,
   input  logic [SRC_W-1:0]       inc_src,
   input  logic [N_SRC-1:0]       clr,
   output logic [N_SRC*CNT_W-1:0] counts,
   output logic [N_SRC-1:0]       over
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (THRESH < 0 || THRESH >= (1 << CNT_W) - 1) begin : g_bad_thresh
      $error("prc_fault_cnt: THRESH must lie below the saturation value");
   end

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      logic [CNT_W-1:0] cnt_q;
      logic             hit;

      assign hit = inc_en && (inc_src == SRC_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (clr[g]) begin
            cnt_q <= '0;
         end else if (hit && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign counts[g*CNT_W +: CNT_W] = cnt_q;
      assign over[g] = (cnt_q > CNT_W'(THRESH));

      // R9: a saturated counter stays saturated until cleared.
      assert_cnt_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q == CNT_MAX && !clr[g] |=> cnt_q == CNT_MAX);

      // R10: a clear always wins.
      assert_cnt_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
         clr[g] |=> cnt_q == '0);
   end

endmodule

// File: rtl/checked_retry_ctrl.sv
module checked_retry_ctrl
   import prc_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int MAX_WORDS = 8,
   parameter int N_PATH    = 2,
   parameter int LOG_DEPTH = 2,
   parameter int CNT_W     = 3,
   parameter int THRESH    = 3,
   localparam int PATH_W   = (N_PATH > 1) ? $clog2(N_PATH) : 1,
   localparam int LOG_W    = PATH_W + 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic [DATA_W-1:0]       s_data,
   input  logic                    s_last,
   input  logic [PATH_W-1:0]       pri_path,
   output logic                    tx_valid,
   input  logic                    tx_ready,
   output logic [DATA_W-1:0]       tx_data,
   output logic                    tx_last,
   output logic [PATH_W-1:0]       tx_path,
   input  logic                    rx_valid,
   output logic                    rx_ready,
   input  logic [DATA_W-1:0]       rx_data,
   input  logic                    rx_last,
   output logic                    xfer_ok,
   output logic                    esc_req,
   input  logic                    esc_ack,
   output logic                    log_valid,
   output logic [LOG_W-1:0]        log_entry,
   input  logic                    log_pop,
   output logic                    log_ovf,
   input  logic [N_PATH-1:0]       err_clr,
   output logic [N_PATH*CNT_W-1:0] err_cnt,
   output logic [N_PATH-1:0]       reconfig_req
);

   localparam int WCNT_W = $clog2(MAX_WORDS + 1);
   localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

   if (DATA_W < CRC_W || DATA_W > 64) begin : g_bad_width
      $error("checked_retry_ctrl: DATA_W must be between 16 and 64");
   end
   if (N_PATH < 2) begin : g_bad_paths
      $error("checked_retry_ctrl: at least two paths are needed");
   end

   xfer_state_t       state_q;
   logic [CRC_W-1:0]  tx_crc_q, rx_crc_q;
   logic [IDX_W-1:0]  send_idx_q;
   logic [1:0]        attempt_q;
   logic [PATH_W-1:0] path_q, alt_path;
   logic              first_cls_q, rx_seen_q;
   logic [WCNT_W-1:0] buf_count;
   logic [DATA_W-1:0] buf_rd, tx_code, rx_code;
   logic              up_hs, tx_hs, rx_hs, rx_end, resp_good, last_payload;
   logic              fault_cls, buf_clr, log_push, cnt_inc;
   logic [LOG_W-1:0]  log_data;

   // Code word placement: zero-extended when the data word is wider.
   if (DATA_W > CRC_W) begin : g_wide
      assign tx_code = {{(DATA_W-CRC_W){1'b0}}, tx_crc_q};
      assign rx_code = {{(DATA_W-CRC_W){1'b0}}, rx_crc_q};
   end else begin : g_exact
      assign tx_code = tx_crc_q;
      assign rx_code = rx_crc_q;
   end

   assign s_ready  = (state_q == ST_IDLE);
   assign tx_valid = (state_q == ST_SEND) || (state_q == ST_CODE);
   assign tx_last  = (state_q == ST_CODE);
   assign tx_data  = (state_q == ST_CODE) ? tx_code : buf_rd;
   assign tx_path  = path_q;
   assign rx_ready = (state_q == ST_WAIT);
   assign esc_req  = (state_q == ST_ESC);

   assign up_hs        = s_valid && s_ready;
   assign tx_hs        = tx_valid && tx_ready;
   assign rx_hs        = rx_valid && rx_ready;
   assign rx_end       = rx_hs && rx_last;
   assign resp_good    = rx_seen_q && (rx_data == rx_code);
   assign last_payload = (WCNT_W'(send_idx_q) + WCNT_W'(1)) == buf_count;
   assign fault_cls    = rx_seen_q ? FLT_MISMATCH : FLT_EMPTY;
   assign alt_path     = (path_q == PATH_W'(N_PATH - 1)) ? '0 : path_q + 1'b1;

   assign buf_clr  = (rx_end && resp_good) || (esc_req && esc_ack);
   assign log_push = rx_end && resp_good && (attempt_q != 2'd0);
   assign log_data = {path_q, attempt_q, first_cls_q};
   assign cnt_inc  = rx_end && !resp_good;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tx_crc_q    <= CRC_SEED;
         rx_crc_q    <= CRC_SEED;
         send_idx_q  <= '0;
         attempt_q   <= '0;
         path_q      <= '0;
         first_cls_q <= FLT_MISMATCH;
         rx_seen_q   <= 1'b0;
         xfer_ok     <= 1'b0;
      end else begin
         xfer_ok <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (up_hs) begin
                  tx_crc_q <= crc_update(tx_crc_q, 64'(s_data), DATA_W);
                  if (s_last) begin
                     state_q    <= ST_SEND;
                     path_q     <= pri_path;
                     attempt_q  <= '0;
                     send_idx_q <= '0;
                  end
               end
            end
            ST_SEND: begin
               if (tx_hs) begin
                  if (last_payload) state_q <= ST_CODE;
                  else              send_idx_q <= send_idx_q + 1'b1;
               end
            end
            ST_CODE: begin
               if (tx_hs) begin
                  state_q   <= ST_WAIT;
                  rx_crc_q  <= CRC_SEED;
                  rx_seen_q <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (rx_hs) begin
                  if (!rx_last) begin
                     rx_crc_q  <= crc_update(rx_crc_q, 64'(rx_data), DATA_W);
                     rx_seen_q <= 1'b1;
                  end else if (resp_good) begin
                     xfer_ok  <= 1'b1;
                     state_q  <= ST_IDLE;
                     tx_crc_q <= CRC_SEED;
                  end else begin
                     if (attempt_q == 2'd0) first_cls_q <= fault_cls;
                     send_idx_q <= '0;
                     if (attempt_q == 2'd2) begin
                        state_q <= ST_ESC;
                     end else begin
                        state_q   <= ST_SEND;
                        attempt_q <= attempt_q + 1'b1;
                        if (attempt_q == 2'd1) path_q <= alt_path;
                     end
                  end
               end
            end
            ST_ESC: begin
               if (esc_ack) begin
                  state_q  <= ST_IDLE;
                  tx_crc_q <= CRC_SEED;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   prc_pkt_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (MAX_WORDS)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (buf_clr),
      .wr_en   (up_hs),
      .wr_data (s_data),
      .rd_idx  (send_idx_q),
      .rd_data (buf_rd),
      .count   (buf_count)
   );

   prc_err_log #(
      .ENTRY_W (LOG_W),
      .DEPTH   (LOG_DEPTH)
   ) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (log_push),
      .push_data (log_data),
      .pop       (log_pop),
      .out_valid (log_valid),
      .out_data  (log_entry),
      .ovf       (log_ovf)
   );

   prc_fault_cnt #(
      .N_SRC  (N_PATH),
      .CNT_W  (CNT_W),
      .THRESH (THRESH)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (cnt_inc),
      .inc_src (path_q),
      .clr     (err_clr),
      .counts  (err_cnt),
      .over    (reconfig_req)
   );

   // R11: a stalled outgoing word holds.
   assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_path));

   // R2: accepting the last upstream word starts sending on the sampled path.
   assert_start_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid && s_ready && s_last |=> !s_ready && tx_valid && tx_path == $past(pri_path));

   // R3: a pass pulse follows the final word of a returning packet.
   assert_ok_after_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ok |-> $past(rx_valid && rx_ready && rx_last));

   // R6: escalation is held until acknowledged, and starts on a returning packet.
   assert_esc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      esc_req && !esc_ack |=> esc_req && !tx_valid);
   assert_esc_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(esc_req) |-> $past(rx_valid && rx_ready && rx_last));

endmodule

// File: tb/test_checked_retry_ctrl.sv
`timescale 1ns/1ps
module test_checked_retry_ctrl;

   typedef struct {
      logic [15:0] d;
      logic        l;
      logic        p;
   } tx_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_last = 1'b0;
   logic [15:0] s_data = '0;
   logic [0:0]  pri_path = '0;
   logic        tx_ready = 1'b1;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [15:0] rx_data = '0;
   logic        esc_ack = 1'b0, log_pop = 1'b0;
   logic [1:0]  err_clr = '0;
   logic        s_ready, tx_valid, tx_last, rx_ready, xfer_ok, esc_req;
   logic        log_valid, log_ovf;
   logic [15:0] tx_data;
   logic [0:0]  tx_path;
   logic [3:0]  log_entry;
   logic [5:0]  err_cnt;
   logic [1:0]  reconfig_req;

   int n_checks = 0;
   int n_errors = 0;
   bit bp = 1'b0;
   tx_item_t exp_q[$];
   logic [3:0] exp_log[$];
   int exp_cnt[2] = '{0, 0};
   bit exp_ovf = 1'b0;
   bit stall_prev = 1'b0;
   logic [15:0] held_d;

   checked_retry_ctrl i_checked_retry_ctrl (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .pri_path(pri_path),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_path(tx_path),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
      .xfer_ok(xfer_ok), .esc_req(esc_req), .esc_ack(esc_ack),
      .log_valid(log_valid), .log_entry(log_entry), .log_pop(log_pop), .log_ovf(log_ovf),
      .err_clr(err_clr), .err_cnt(err_cnt), .reconfig_req(reconfig_req)
   );

   always #10 clk = ~clk;

   function automatic logic [15:0] crc16(input logic [15:0] c, input logic [15:0] w);
      logic [15:0] r;
      r = c;
      for (int i = 15; i >= 0; i--) begin
         if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
         else              r = {r[14:0], 1'b0};
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Outgoing stall driver, changed mid-high so negedge samples are stable.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         tx_ready = bp ? ~tx_ready : 1'b1;
      end
   end

   // Monitor: pops the scoreboard on every outgoing handshake.
   always @(negedge clk) begin
      if (rst_n && tx_valid) begin
         if (stall_prev) check(tx_data == held_d, "R11", "held word", tx_data, held_d);
         if (tx_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "unexpected outgoing word", tx_data, 0);
            end else begin
               tx_item_t e;
               e = exp_q.pop_front();
               check(tx_data == e.d, "R1", "outgoing word", tx_data, e.d);
               check(tx_last == e.l, "R1", "code marker", tx_last, e.l);
               check(tx_path == e.p, "R5", "path", tx_path, e.p);
            end
         end
      end
      stall_prev = rst_n && tx_valid && !tx_ready;
      held_d = tx_data;
   end

   task automatic send_resp(input bit good, input bit empty);
      logic [15:0] w[2];
      logic [15:0] c;
      w[0] = 16'hA5A5;
      w[1] = 16'h3C3C;
      c = crc16(crc16(16'hFFFF, w[0]), w[1]);
      if (!good) c = c ^ 16'h0100;
      if (empty) begin
         rx_valid = 1'b1; rx_data = c; rx_last = 1'b1;
         while (!rx_ready) @(negedge clk);
         @(negedge clk);
      end else begin
         for (int i = 0; i < 3; i++) begin
            rx_valid = 1'b1;
            rx_data  = (i < 2) ? w[i] : c;
            rx_last  = (i == 2);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
         end
      end
      rx_valid = 1'b0;
      rx_last  = 1'b0;
   endtask

   task automatic check_counters();
      for (int p = 0; p < 2; p++) begin
         check(err_cnt[p*3 +: 3] == 3'(exp_cnt[p]), "R9", "path counter", err_cnt[p*3 +: 3], exp_cnt[p]);
         check(reconfig_req[p] == (exp_cnt[p] > 3), "R10", "reconfig request", reconfig_req[p], exp_cnt[p] > 3);
      end
   endtask

   task automatic run_xfer(input int n, input int pri, input int nfail, input bit empty_first, input logic [15:0] seed);
      logic [15:0] w[8];
      logic [15:0] c;
      int att, p;
      bit good;
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         w[i] = seed + 16'(i * 16'h1357);
         c = crc16(c, w[i]);
      end
      att = (nfail >= 3) ? 3 : nfail + 1;
      for (int a = 0; a < att; a++) begin
         p = (a < 2) ? pri : (pri + 1) % 2;
         for (int i = 0; i < n; i++) exp_q.push_back('{d: w[i], l: 1'b0, p: 1'(p)});
         exp_q.push_back('{d: c, l: 1'b1, p: 1'(p)});
      end
      for (int i = 0; i < n; i++) begin
         s_valid = 1'b1; s_data = w[i]; s_last = (i == n - 1); pri_path = 1'(pri);
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
      for (int a = 0; a < att; a++) begin
         good = (a == nfail);
         p = (a < 2) ? pri : (pri + 1) % 2;
         send_resp(good, empty_first && a == 0);
         if (!good && exp_cnt[p] < 7) exp_cnt[p]++;
      end
      check(exp_q.size() == 0, "R4", "outstanding resends", exp_q.size(), 0);
      check_counters();
      if (nfail < 3) begin
         check(xfer_ok == 1'b1, "R3", "pass pulse", xfer_ok, 1);
         check(s_ready == 1'b1, "R3", "ready after pass", s_ready, 1);
         if (nfail > 0) begin
            p = (nfail < 2) ? pri : (pri + 1) % 2;
            if (exp_log.size() < 2) exp_log.push_back({1'(p), 2'(nfail), empty_first});
            else exp_ovf = 1'b1;
         end
         check(log_ovf == exp_ovf, "R8", "overflow flag", log_ovf, exp_ovf);
      end else begin
         check(esc_req == 1'b1, "R6", "escalation raised", esc_req, 1);
         check(s_ready == 1'b0, "R6", "upstream held", s_ready, 0);
         repeat (3) @(negedge clk);
         check(esc_req == 1'b1 && tx_valid == 1'b0, "R6", "escalation held", {esc_req, tx_valid}, 2);
         esc_ack = 1'b1;
         @(negedge clk);
         esc_ack = 1'b0;
         check(esc_req == 1'b0 && s_ready == 1'b1, "R6", "idle after ack", {esc_req, s_ready}, 1);
      end
   endtask

   task automatic drain_log();
      logic [3:0] e;
      while (exp_log.size() > 0) begin
         e = exp_log.pop_front();
         check(log_valid == 1'b1, "R8", "log entry present", log_valid, 1);
         check(log_entry == e, "R7", "log entry", log_entry, e);
         log_pop = 1'b1;
         @(negedge clk);
         log_pop = 1'b0;
      end
      check(log_valid == 1'b0, "R8", "log empty", log_valid, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "R12", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: idle state after reset
      check(s_ready == 1'b1, "R12", "s_ready", s_ready, 1);
      check({tx_valid, rx_ready, esc_req, log_valid, log_ovf, xfer_ok} == 6'b0, "R12", "idle outputs",
            {tx_valid, rx_ready, esc_req, log_valid, log_ovf, xfer_ok}, 0);
      check(err_cnt == 6'b0, "R12", "counters", err_cnt, 0);

      run_xfer(3, 0, 0, 1'b0, 16'h1000);  // R1 R2 R3: clean pass, no log
      check(log_valid == 1'b0, "R7", "no entry on first pass", log_valid, 0);
      run_xfer(1, 0, 1, 1'b0, 16'h2000);  // R4: same-path resend
      run_xfer(4, 0, 2, 1'b0, 16'h3000);  // R5: alternate path
      run_xfer(2, 1, 1, 1'b1, 16'h4000);  // R8: log full, entry dropped; empty return class
      drain_log();
      run_xfer(2, 0, 3, 1'b1, 16'h5000);  // R6: escalation, R10 threshold on path 0
      bp = 1'b1;
      run_xfer(5, 1, 0, 1'b0, 16'h6000);  // R11: stalled outgoing path
      bp = 1'b0;
      run_xfer(3, 0, 3, 1'b0, 16'h7000);  // R9: path 0 reaches saturation
      run_xfer(3, 0, 3, 1'b0, 16'h7100);  // R9: stays saturated
      err_clr = 2'b01;
      @(negedge clk);
      err_clr = 2'b00;
      exp_cnt[0] = 0;
      check_counters();                   // R10: only path 0 cleared
      run_xfer(2, 1, 2, 1'b0, 16'h8000);  // R5: alternate wraps to path 0
      drain_log();

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule